// File: doc/BRIEF.md
# Windowed Register Bank Controller

This block presents sixteen 16-bit general registers to a datapath without owning any fixed register storage. Every register number is turned into a word address in a shared 256-word on-chip RAM by adding it to a context pointer. Two combinational read ports and one clocked write port each carry a 4-bit register number. A task change or an interrupt entry therefore only has to move the pointer. It never copies register contents.

The block also keeps the stack pointer and runs four context commands. Each command is a one-cycle `cmd_go` pulse together with an operation code.

- An absolute switch pushes the current pointer and loads a supplied pointer. It finishes in one cycle.
- A stack-carved switch allocates a bank of 1 to 16 words just below the stack pointer and pushes the old pointer beneath that bank. It takes two cycles.
- Each switch has a matching return.

A new window may partly overlap the old one. With the new pointer set to the old pointer plus 6, caller R6/R7 and callee R0/R1 are the same RAM words, so parameters need no copying. The stack grows downward: a push pre-decrements the stack pointer and a pop post-increments it.

Top module: `regwin_ctrl`

## Requirements
- R1: After reset the context pointer is 240, the stack pointer is 240, and busy, done, the size error flag and the overflow flag are all 0. RAM contents are undefined after reset.
- R2: Register n on either read port returns RAM word (context pointer + n), combinationally. A write with `wr_en` high stores `wr_data` into word (context pointer + `wr_idx`) at the clock edge.
- R3: When a read port selects the RAM word that the register write is storing in the same cycle, the read port shows the new data. This also holds when the read and the write reach the same word through different register numbers of overlapping windows.
- R4: Operation 0 (absolute switch) completes at the edge that accepts it:
  - the old context pointer is stored at word (stack pointer - 1);
  - the stack pointer decrements by one;
  - the context pointer takes `cmd_cp`;
  - `done` is high for the following cycle and `busy` never rises.
- R5: Operation 2 (absolute return) completes in one cycle. It loads the context pointer from the low 8 bits of RAM word (stack pointer) and increments the stack pointer.
- R6: Operation 1 (stack switch, size s) runs over two cycles:
  - it sets `busy` for the cycle after acceptance;
  - at the next edge the new context pointer becomes (stack pointer - s) and the old pointer is stored at word (new pointer - 1);
  - the stack pointer becomes (new pointer - 1) and `done` rises.
- R7: Operation 3 (stack return, size s) runs over two cycles like R6. It then loads the context pointer from word (stack pointer) and sets the stack pointer to (stack pointer + 1 + s).
- R8: With an absolute switch to (old pointer + 6), the callee's R0 and R1 name the same storage as the caller's R6 and R7, in both directions.
- R9: While `busy` is high, register writes and new commands have no effect.
- R10: A stack switch or stack return whose size is 0 or larger than 16 sets the size error flag. It leaves both pointers unchanged and pulses `done` without `busy`.
- R11: The overflow flag is set, and both pointers are left unchanged, in each of these cases:
  - an absolute switch with a stack pointer of 0, or with `cmd_cp` above 240;
  - an absolute return with a stack pointer of 255;
  - a stack switch whose new bank, or the word below it, would fall below address 0, or whose new pointer would exceed 240;
  - a stack return whose resulting stack pointer would exceed 255.
- R12: `done` is a one-cycle pulse per command. The error and overflow flags hold their value until the next accepted command, which clears them at its acceptance edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_a_idx | input | 4 | Register number for read port A |
| rd_a_data | output | 16 | Read port A data |
| rd_b_idx | input | 4 | Register number for read port B |
| rd_b_data | output | 16 | Read port B data |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Register number for the write |
| wr_data | input | 16 | Write data |
| cmd_go | input | 1 | One-cycle command pulse |
| cmd_op | input | 2 | 0 absolute switch, 1 stack switch, 2 absolute return, 3 stack return |
| cmd_cp | input | 8 | New context pointer for operation 0 |
| cmd_size | input | 5 | Bank size for operations 1 and 3 |
| busy | output | 1 | A two-cycle command is in progress; register writes and commands are ignored |
| done | output | 1 | Command finished (one cycle) |
| err_size | output | 1 | Last command had an illegal bank size |
| ovf | output | 1 | Last command would have left the RAM range |
| cp_out | output | 8 | Current context pointer |
| sp_out | output | 8 | Current stack pointer |

## Verification
The bench checks that a write during the busy cycle of a stack switch is dropped. A design that lets it through would corrupt R0 of the outer bank, and the bench reads that register back after the return. It checks that a second pulse issued while busy is ignored. A design that queues it would move the stack pointer once more. It sends a write and a read to the same word in one cycle and through the aliased caller and callee windows. A design without forwarding shows stale data, and one that aliases wrongly loses the parameter. The remaining checks cover the size limits 0, 16 and 17 and the top-of-RAM limits, where a design that wrapped would move the pointers instead of raising a flag.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

  typedef enum logic [1:0] {
    OP_SW_ABS  = 2'd0,
    OP_SW_STK  = 2'd1,
    OP_RET_ABS = 2'd2,
    OP_RET_STK = 2'd3
  } win_op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } seq_st_e;

endpackage

// File: rtl/regwin_addr.sv
module regwin_addr #(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 4
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] addr
);
  // Window offset added modulo the RAM size; range is guarded by the sequencer.
  assign addr = base + ADDR_W'(idx);
endmodule

// File: rtl/regwin_ram.sv
module regwin_ram #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] rd_a_addr,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [ADDR_W-1:0] rd_b_addr,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic [ADDR_W-1:0] pop_addr,
  output logic [DATA_W-1:0] pop_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              push_en,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [DATA_W-1:0] push_data
);
  localparam int DEPTH = 2 ** ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Storage carries no reset; user write wins over a colliding push.
  always_ff @(posedge clk) begin
    if (push_en) mem[push_addr] <= push_data;
    if (wr_en)   mem[wr_addr]   <= wr_data;
  end

  // Reads bypass the user write landing in the same cycle.
  always_comb begin
    rd_a_data = (wr_en && (wr_addr == rd_a_addr)) ? wr_data : mem[rd_a_addr];
    rd_b_data = (wr_en && (wr_addr == rd_b_addr)) ? wr_data : mem[rd_b_addr];
    pop_data  = (wr_en && (wr_addr == pop_addr))  ? wr_data : mem[pop_addr];
  end
endmodule

// File: rtl/regwin_seq.sv
module regwin_seq
  import regwin_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8,
  parameter int NREG   = 16,
  parameter int SIZE_W = 5,
  parameter logic [ADDR_W-1:0] CP_RST = 8'd240,
  parameter logic [ADDR_W-1:0] SP_RST = 8'd240
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_go,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_cp,
  input  logic [SIZE_W-1:0] cmd_size,
  input  logic [DATA_W-1:0] pop_data,
  output logic [ADDR_W-1:0] cp_q,
  output logic [ADDR_W-1:0] sp_q,
  output logic              busy,
  output logic              done_q,
  output logic              err_q,
  output logic              ovf_q,
  output logic              push_en,
  output logic [ADDR_W-1:0] push_addr,
  output logic [DATA_W-1:0] push_data
);
  localparam int AW = ADDR_W;
  localparam logic [AW:0]   TOP_X = (AW+1)'(2 ** AW - NREG);
  localparam logic [AW:0]   MAX_X = (AW+1)'(2 ** AW - 1);
  localparam logic [AW-1:0] ONE   = AW'(1);

  seq_st_e          st_q, st_d;
  win_op_e          op_in, lop_q, lop_d;
  logic [AW-1:0]    lsize_q, lsize_d;
  logic [AW-1:0]    cp_d, sp_d;
  logic             done_d, err_d, ovf_d;
  logic [AW:0]      sp_x, size_x, cp_x, newcp_x;
  logic [AW-1:0]    bank_cp;
  logic             size_bad;

  assign op_in    = win_op_e'(cmd_op);
  assign sp_x     = {1'b0, sp_q};
  assign size_x   = (AW+1)'(cmd_size);
  assign cp_x     = {1'b0, cmd_cp};
  assign newcp_x  = sp_x - size_x;
  assign size_bad = (cmd_size == '0) || (size_x > (AW+1)'(NREG));
  assign bank_cp  = sp_q - lsize_q;
  assign busy     = (st_q == ST_BUSY);

  // Next-state logic
  always_comb begin
    st_d      = st_q;
    lop_d     = lop_q;
    lsize_d   = lsize_q;
    cp_d      = cp_q;
    sp_d      = sp_q;
    done_d    = 1'b0;
    err_d     = err_q;
    ovf_d     = ovf_q;
    push_en   = 1'b0;
    push_addr = sp_q - ONE;
    push_data = DATA_W'(cp_q);
    if (st_q == ST_IDLE) begin
      if (cmd_go) begin
        err_d = 1'b0;
        ovf_d = 1'b0;
        unique case (op_in)
          OP_SW_ABS: begin
            done_d = 1'b1;
            if ((sp_q == '0) || (cp_x > TOP_X)) begin
              ovf_d = 1'b1;
            end else begin
              push_en = 1'b1;
              sp_d    = sp_q - ONE;
              cp_d    = cmd_cp;
            end
          end
          OP_RET_ABS: begin
            done_d = 1'b1;
            if (sp_x == MAX_X) begin
              ovf_d = 1'b1;
            end else begin
              cp_d = pop_data[AW-1:0];
              sp_d = sp_q + ONE;
            end
          end
          OP_SW_STK: begin
            if (size_bad) begin
              err_d  = 1'b1;
              done_d = 1'b1;
            end else if ((sp_x < size_x + 1) || (newcp_x > TOP_X)) begin
              ovf_d  = 1'b1;
              done_d = 1'b1;
            end else begin
              st_d    = ST_BUSY;
              lop_d   = op_in;
              lsize_d = AW'(cmd_size);
            end
          end
          OP_RET_STK: begin
            if (size_bad) begin
              err_d  = 1'b1;
              done_d = 1'b1;
            end else if (sp_x + size_x + 1 > MAX_X) begin
              ovf_d  = 1'b1;
              done_d = 1'b1;
            end else begin
              st_d    = ST_BUSY;
              lop_d   = op_in;
              lsize_d = AW'(cmd_size);
            end
          end
          default: ;
        endcase
      end
    end else begin
      st_d   = ST_IDLE;
      done_d = 1'b1;
      if (lop_q == OP_SW_STK) begin
        push_en   = 1'b1;
        push_addr = bank_cp - ONE;
        cp_d      = bank_cp;
        sp_d      = bank_cp - ONE;
      end else begin
        cp_d = pop_data[AW-1:0];
        sp_d = sp_q + lsize_q + ONE;
      end
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      lop_q   <= OP_SW_ABS;
      lsize_q <= '0;
      cp_q    <= CP_RST;
      sp_q    <= SP_RST;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      lop_q   <= lop_d;
      lsize_q <= lsize_d;
      cp_q    <= cp_d;
      sp_q    <= sp_d;
      done_q  <= done_d;
      err_q   <= err_d;
      ovf_q   <= ovf_d;
    end
  end
endmodule

// File: rtl/regwin_ctrl.sv
module regwin_ctrl #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8,
  parameter int NREG   = 16,
  parameter int IDX_W  = $clog2(NREG),
  parameter int SIZE_W = $clog2(NREG) + 1,
  parameter logic [ADDR_W-1:0] CP_RST = 8'd240,
  parameter logic [ADDR_W-1:0] SP_RST = 8'd240
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cmd_go,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_cp,
  input  logic [SIZE_W-1:0] cmd_size,
  output logic              busy,
  output logic              done,
  output logic              err_size,
  output logic              ovf,
  output logic [ADDR_W-1:0] cp_out,
  output logic [ADDR_W-1:0] sp_out
);
  localparam int NPORT = 3;

  logic [1:0]        rs_q;
  logic              rst_sync_n;
  logic [ADDR_W-1:0] cp_q, sp_q;
  logic [IDX_W-1:0]  port_idx  [NPORT];
  logic [ADDR_W-1:0] port_addr [NPORT];
  logic              push_en;
  logic [ADDR_W-1:0] push_addr;
  logic [DATA_W-1:0] push_data, pop_data;
  logic              wr_gated;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  assign port_idx[0] = rd_a_idx;
  assign port_idx[1] = rd_b_idx;
  assign port_idx[2] = wr_idx;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    regwin_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) addr_i (
      .base (cp_q),
      .idx  (port_idx[p]),
      .addr (port_addr[p])
    );
  end

  assign wr_gated = wr_en && !busy;

  regwin_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) ram_i (
    .clk       (clk),
    .rd_a_addr (port_addr[0]),
    .rd_a_data (rd_a_data),
    .rd_b_addr (port_addr[1]),
    .rd_b_data (rd_b_data),
    .pop_addr  (sp_q),
    .pop_data  (pop_data),
    .wr_en     (wr_gated),
    .wr_addr   (port_addr[2]),
    .wr_data   (wr_data),
    .push_en   (push_en),
    .push_addr (push_addr),
    .push_data (push_data)
  );

  regwin_seq #(
    .DATA_W (DATA_W), .ADDR_W (ADDR_W), .NREG (NREG), .SIZE_W (SIZE_W),
    .CP_RST (CP_RST), .SP_RST (SP_RST)
  ) seq_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cmd_go    (cmd_go),
    .cmd_op    (cmd_op),
    .cmd_cp    (cmd_cp),
    .cmd_size  (cmd_size),
    .pop_data  (pop_data),
    .cp_q      (cp_q),
    .sp_q      (sp_q),
    .busy      (busy),
    .done_q    (done),
    .err_q     (err_size),
    .ovf_q     (ovf),
    .push_en   (push_en),
    .push_addr (push_addr),
    .push_data (push_data)
  );

  assign cp_out = cp_q;
  assign sp_out = sp_q;
endmodule

// File: rtl/regwin_chk.sv
module regwin_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_go,
  input logic [1:0]        cmd_op,
  input logic              busy,
  input logic              done,
  input logic              err_size,
  input logic              ovf,
  input logic [ADDR_W-1:0] cp_out,
  input logic [ADDR_W-1:0] sp_out
);
  // R6: busy lasts exactly one cycle and is followed by done
  a_r6_busy_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy && done));

  // R4: an accepted absolute switch lowers the stack pointer by one unless it overflows
  a_r4_abs_push: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && !busy && cmd_op == 2'd0) |=> (ovf || sp_out == $past(sp_out) - ADDR_W'(1)));

  // R5: an accepted absolute return raises the stack pointer by one unless it overflows
  a_r5_abs_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && !busy && cmd_op == 2'd2) |=> (ovf || sp_out == $past(sp_out) + ADDR_W'(1)));

  // R9: pointers hold while a command waits in the busy cycle
  a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && busy) |-> (cp_out == $past(cp_out) && sp_out == $past(sp_out)));

  // R10 / R11: a rejected command leaves both pointers untouched
  a_r10_r11_reject_no_move: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (err_size || ovf)) |-> (cp_out == $past(cp_out) && sp_out == $past(sp_out)));

  // R12: error and overflow are not reported together
  a_r12_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_size && ovf));
endmodule

bind regwin_ctrl regwin_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .cmd_go   (cmd_go),
  .cmd_op   (cmd_op),
  .busy     (busy),
  .done     (done),
  .err_size (err_size),
  .ovf      (ovf),
  .cp_out   (cp_out),
  .sp_out   (sp_out)
);

// File: tb/regwin_ctrl_tb_top.sv
`timescale 1ns/1ps
module regwin_ctrl_tb_top;
  logic        clk;
  logic        rst_n;
  logic [3:0]  rd_a_idx, rd_b_idx, wr_idx;
  logic [15:0] rd_a_data, rd_b_data, wr_data;
  logic        wr_en, cmd_go;
  logic [1:0]  cmd_op;
  logic [7:0]  cmd_cp;
  logic [4:0]  cmd_size;
  logic        busy, done, err_size, ovf;
  logic [7:0]  cp_out, sp_out;

  int vectors = 0;
  int miscompares = 0;

  // Entries: {register number, data}
  localparam logic [19:0] VEC [16] = '{
    {4'd0,  16'h1A01}, {4'd7,  16'h2B17}, {4'd14, 16'h3C2E}, {4'd5,  16'h4D35},
    {4'd12, 16'h5E4C}, {4'd3,  16'h6F53}, {4'd10, 16'h706A}, {4'd1,  16'h8171},
    {4'd8,  16'h9288}, {4'd15, 16'hA39F}, {4'd6,  16'hB4A6}, {4'd13, 16'hC5BD},
    {4'd4,  16'hD6C4}, {4'd11, 16'hE7DB}, {4'd2,  16'hF8E2}, {4'd9,  16'h09F9}
  };

  regwin_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .cmd_go(cmd_go), .cmd_op(cmd_op), .cmd_cp(cmd_cp), .cmd_size(cmd_size),
    .busy(busy), .done(done), .err_size(err_size), .ovf(ovf),
    .cp_out(cp_out), .sp_out(sp_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [15:0] exp_of(input logic [3:0] idx);
    logic [15:0] r = '0;
    for (int k = 0; k < 16; k++) if (VEC[k][19:16] == idx) r = VEC[k][15:0];
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] idx, input logic [15:0] d);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic issue(input logic [1:0] op, input logic [7:0] cp, input logic [4:0] sz);
    cmd_go = 1'b1; cmd_op = op; cmd_cp = cp; cmd_size = sz;
    @(negedge clk);
    cmd_go = 1'b0;
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_data = '0;
    rd_a_idx = '0; rd_b_idx = '0;
    cmd_go = 1'b0; cmd_op = '0; cmd_cp = '0; cmd_size = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 cp", cp_out, 240);
    chk("R1 sp", sp_out, 240);
    chk("R1 flags", {busy, done, err_size, ovf}, 0);

    // R2 table walk: write all registers, then read on both ports
    for (int i = 0; i < 16; i++) wr_reg(VEC[i][19:16], VEC[i][15:0]);
    for (int i = 0; i < 16; i++) begin
      rd_a_idx = VEC[i][19:16];
      rd_b_idx = ~VEC[i][19:16];
      #1;
      chk("R2 port A", rd_a_data, VEC[i][15:0]);
      chk("R2 port B", rd_b_data, exp_of(~VEC[i][19:16]));
      @(negedge clk);
    end

    // R3 same-cycle write forwarding
    wr_en = 1'b1; wr_idx = 4'd3; wr_data = 16'hAAAA; rd_a_idx = 4'd3; #1;
    chk("R3 forward", rd_a_data, 16'hAAAA);
    @(negedge clk); wr_en = 1'b0;

    // R4 absolute switch
    issue(2'd0, 8'd100, 5'd0);
    chk("R4 cp", cp_out, 100);
    chk("R4 sp", sp_out, 239);
    chk("R4 done/busy", {done, busy}, 2'b10);
    @(negedge clk);
    chk("R12 done pulse", done, 0);

    // R8 overlap by six
    wr_reg(4'd6, 16'h1111);
    wr_reg(4'd7, 16'h2222);
    issue(2'd0, 8'd106, 5'd0);
    chk("R4 sp second push", sp_out, 238);
    rd_a_idx = 4'd0; rd_b_idx = 4'd1; #1;
    chk("R8 callee R0", rd_a_data, 16'h1111);
    chk("R8 callee R1", rd_b_data, 16'h2222);
    @(negedge clk);
    // R3 alias: write callee R0 and read it as callee R0 in the same cycle
    wr_en = 1'b1; wr_idx = 4'd0; wr_data = 16'h3333; rd_a_idx = 4'd0; #1;
    chk("R3 alias forward", rd_a_data, 16'h3333);
    @(negedge clk); wr_en = 1'b0;

    // R5 absolute returns
    issue(2'd2, 8'd0, 5'd0);
    chk("R5 cp", cp_out, 100);
    chk("R5 sp", sp_out, 239);
    rd_a_idx = 4'd6; #1;
    chk("R8 caller R6", rd_a_data, 16'h3333);
    @(negedge clk);
    issue(2'd2, 8'd0, 5'd0);
    chk("R5 cp outer", cp_out, 240);
    chk("R5 sp outer", sp_out, 240);

    // R6 stack switch with R9 ignored write/command in busy cycle
    issue(2'd1, 8'd0, 5'd4);
    chk("R6 busy", {busy, done}, 2'b10);
    chk("R6 cp held", cp_out, 240);
    cmd_go = 1'b1; cmd_op = 2'd0; cmd_cp = 8'd50;
    wr_en = 1'b1; wr_idx = 4'd0; wr_data = 16'hDEAD;
    @(negedge clk);
    cmd_go = 1'b0; wr_en = 1'b0;
    chk("R6 cp", cp_out, 236);
    chk("R6 sp", sp_out, 235);
    chk("R6 done", {busy, done}, 2'b01);
    @(negedge clk);
    chk("R9 command ignored sp", sp_out, 235);
    chk("R9 command ignored cp", cp_out, 236);

    // R7 stack return
    issue(2'd3, 8'd0, 5'd4);
    chk("R7 busy", busy, 1);
    @(negedge clk);
    chk("R7 cp", cp_out, 240);
    chk("R7 sp", sp_out, 240);
    rd_a_idx = 4'd0; #1;
    chk("R9 write ignored", rd_a_data, exp_of(4'd0));
    @(negedge clk);

    // R10 illegal sizes
    issue(2'd1, 8'd0, 5'd0);
    chk("R10 size0 err", {err_size, done, busy}, 3'b110);
    chk("R10 size0 sp", sp_out, 240);
    @(negedge clk);
    chk("R12 err held", {err_size, done}, 2'b10);
    issue(2'd3, 8'd0, 5'd17);
    chk("R10 size17 err", err_size, 1);
    chk("R10 size17 cp", cp_out, 240);

    // R11 overflow cases
    issue(2'd0, 8'd241, 5'd0);
    chk("R11 abs ovf/R12 err cleared", {ovf, err_size}, 2'b10);
    chk("R11 abs sp", sp_out, 240);
    issue(2'd3, 8'd0, 5'd16);
    chk("R11 ret ovf", {ovf, busy}, 2'b10);
    chk("R11 ret cp", cp_out, 240);

    // R6 largest bank; flags clear at acceptance
    issue(2'd1, 8'd0, 5'd16);
    chk("R12 ovf cleared", {ovf, busy}, 2'b01);
    @(negedge clk);
    chk("R6 size16 cp", cp_out, 224);
    chk("R6 size16 sp", sp_out, 223);

    summary();
    $finish;
  end
endmodule